// File: doc/BRIEF.md
# Chip-select region decoder

This block maps a 32-bit physical address onto one of eight chip-select windows. Each window has its own configuration word with three fields. A base field places the window on a 16 MB boundary inside a 1 GB span. A size-mask field sets the window size to 16, 32, 64, 128 or 256 MB. An enable bit admits the window to decoding. Every request is answered one cycle later with a registered response:
- a one-hot chip-select,
- the offset inside the window,
- hit, miss and overlap flags,
- a route flag taken from the winning window's attached device kind: a plain memory-mapped device or a NAND command/data path.

The block also flags enabled windows whose mask code is not one of the permitted sizes.

Configuration words are written through a small update sequencer. A write that alters any stored bit takes the window out of decoding first, installs the new word, and then brings the window back. The sequencer has three states:
- **STEADY**: idle, and accepting writes.
- **DETACH**: the window is held out of decoding and still holds its old word.
- **ATTACH**: the window is still held out and now holds its new word.

Its transitions are:
- *changed-write*: STEADY to DETACH.
- *install*: DETACH to ATTACH, in which the word is stored.
- *release*: ATTACH to STEADY.
- *no-change*: STEADY stays STEADY on a write that alters no stored bit.

A write that arrives while the sequencer is not in STEADY is dropped.

Top module: `cs_region_decoder`

## Requirements
- R1: Configuration word layout: base in bits 5:0, enable in bit 6, size mask in bits 11:8. Only those bits (0x0000_0F7F) are stored. A readback returns the stored bits, with all other bits zero.
- R2: After reset, window 0 reads 0x0000_0F40 (base 0, enabled, mask 0xF) and every other window reads 0x0000_0F00 (disabled). No response is flagged.
- R3: An enabled window matches when all of the following hold. Address bits 31:30 are zero. Address bits 29:28 equal base bits 5:4. Address bits 27:24 equal base bits 3:0 at every position where the mask bit is 1. Positions where the mask bit is 0 are ignored, so the window aliases.
- R4: The reported offset is address bits 27:0 with the bits under the ones of the mask (bits 27:24) cleared.
- R5: When several windows match, the lowest-numbered one wins and the overlap flag is set. The chip-select is one-hot, with bit k for window k.
- R6: A request that matches no window gives miss=1, hit=0, chip-select 0, offset 0 and both route flags 0.
- R7: The device kind of window k is `dev_kind[2k+1:2k]`. Kind 0 raises the memory route and kind 2 raises the NAND route. Kinds 1 and 3 raise neither route, while hit is still reported.
- R8: `cfg_err[k]` is 1 when window k is enabled and its mask is not 0x8, 0xC, 0xE or 0xF. Mask 0x0 is also legal when ALLOW_FULL_SPAN is nonzero, which is not the default.
- R9: A write that changes stored bits is taken in STEADY. The window is then excluded from requests taken in the next two cycles (DETACH, ATTACH). Readback shows the new word from the ATTACH cycle on, and decoding uses it after release.
- R10: A write that changes no stored bit has no effect: no update sequence starts, and the window keeps decoding in the following cycle.
- R11: A write presented while the sequencer is in DETACH or ATTACH is dropped and leaves its target word unchanged.
- R12: A request is answered exactly one cycle later, with `rsp_valid` high. Without a request, all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | 3 | Window index for the write |
| cfg_wr_data | input | 32 | Configuration word to write |
| cfg_rd_idx | input | 3 | Window index for readback |
| cfg_rd_data | output | 32 | Stored configuration word of `cfg_rd_idx` |
| dev_kind | input | 16 | Two-bit attached device kind per window |
| req_valid | input | 1 | Address request strobe |
| req_addr | input | 32 | Physical address to decode |
| rsp_valid | output | 1 | Response valid, one cycle after a request |
| rsp_hit | output | 1 | Some window matched |
| rsp_miss | output | 1 | No window matched |
| rsp_overlap | output | 1 | More than one window matched |
| rsp_cs | output | 8 | One-hot winning chip-select |
| rsp_offset | output | 28 | Offset inside the winning window |
| rsp_to_mem | output | 1 | Hit routed to the memory-mapped device |
| rsp_to_nand | output | 1 | Hit routed to the NAND path |
| cfg_err | output | 8 | Enabled window with an illegal mask code |

## Verification
A decode and a configuration update can land in the same cycle. A request can be taken on the very edge at which a changed write moves the sequencer to DETACH, and further requests can follow while it is in DETACH and ATTACH. The bench drives a write to window 0 together with a request into its old window. It expects a hit on that first edge, misses on the two excluded edges, and a hit at the new base only after release. In the same sequence it presents a second write during DETACH and checks through readback that this write was dropped. A bench model of the stored words predicts every response under random windows, masks and device kinds.

// File: rtl/csd_pkg.sv
package csd_pkg;

    localparam int WORD_W    = 32;
    localparam int BASE_W    = 6;
    localparam int MASK_W    = 4;
    localparam int VALID_POS = 6;
    localparam int MASK_POS  = 8;

    localparam logic [WORD_W-1:0] STORE_BITS     = 32'h0000_0F7F;
    localparam logic [WORD_W-1:0] WORD_RST_FIRST = 32'h0000_0F40;
    localparam logic [WORD_W-1:0] WORD_RST_OTHER = 32'h0000_0F00;

    localparam logic [1:0] KIND_MMIO = 2'd0;
    localparam logic [1:0] KIND_NAND = 2'd2;

    typedef enum logic [1:0] {
        UPD_STEADY = 2'd0,
        UPD_DETACH = 2'd1,
        UPD_ATTACH = 2'd2
    } upd_state_e;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              valid;
        logic [BASE_W-1:0] base;
    } region_cfg_t;

    function automatic region_cfg_t unpack_word(input logic [WORD_W-1:0] w);
        region_cfg_t c;
        c.base  = w[BASE_W-1:0];
        c.valid = w[VALID_POS];
        c.mask  = w[MASK_POS +: MASK_W];
        return c;
    endfunction

    function automatic logic mask_is_legal(input logic [MASK_W-1:0] m,
                                           input logic allow_full);
        logic ok;
        case (m)
            4'h8, 4'hC, 4'hE, 4'hF: ok = 1'b1;
            4'h0:                   ok = allow_full;
            default:                ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/csd_region_file.sv
module csd_region_file
    import csd_pkg::*;
#(
    parameter int N_CS  = 8,
    parameter int IDX_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [WORD_W-1:0]        rd_data,
    output logic [N_CS*WORD_W-1:0]   words,
    output logic [N_CS-1:0]          blocked,
    output upd_state_e               state
);

    logic [WORD_W-1:0] word_q [N_CS];
    upd_state_e        st_q, st_d;
    logic [IDX_W-1:0]  pend_idx_q;
    logic [WORD_W-1:0] pend_word_q;
    logic [WORD_W-1:0] wr_kept;
    logic              wr_in_range;
    logic              wr_differs;

    assign wr_kept     = wr_data & STORE_BITS;
    assign wr_in_range = (int'(wr_idx) < N_CS);
    assign wr_differs  = wr_en && wr_in_range && (wr_kept != word_q[wr_idx]);

    // next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            UPD_STEADY: if (wr_differs) st_d = UPD_DETACH;
            UPD_DETACH: st_d = UPD_ATTACH;
            UPD_ATTACH: st_d = UPD_STEADY;
            default:    st_d = UPD_STEADY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= UPD_STEADY;
        else        st_q <= st_d;
    end

    // pending write capture, only accepted while steady
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_idx_q  <= '0;
            pend_word_q <= '0;
        end else if (st_q == UPD_STEADY && wr_differs) begin
            pend_idx_q  <= wr_idx;
            pend_word_q <= wr_kept;
        end
    end

    // configuration storage, installed on leaving DETACH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CS; i++)
                word_q[i] <= (i == 0) ? WORD_RST_FIRST : WORD_RST_OTHER;
        end else if (st_q == UPD_DETACH) begin
            word_q[pend_idx_q] <= pend_word_q;
        end
    end

    // outputs of the sequencer
    always_comb begin
        blocked = '0;
        unique case (st_q)
            UPD_DETACH, UPD_ATTACH: blocked[pend_idx_q] = 1'b1;
            default: ;
        endcase
    end

    assign state   = st_q;
    assign rd_data = word_q[rd_idx];

    for (genvar g = 0; g < N_CS; g++) begin : g_flat
        assign words[g*WORD_W +: WORD_W] = word_q[g];
    end

endmodule

// File: rtl/csd_match.sv
module csd_match
    import csd_pkg::*;
#(
    parameter int N_CS            = 8,
    parameter int ADDR_W          = 32,
    parameter int SPAN_LSB        = 24,
    parameter int OFS_W           = 28,
    parameter int ALLOW_FULL_SPAN = 0
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [N_CS*WORD_W-1:0]  words,
    input  logic [N_CS-1:0]         blocked,
    output logic [N_CS-1:0]         match,
    output logic [N_CS-1:0]         cfg_err,
    output logic [N_CS*OFS_W-1:0]   offsets
);

    localparam int SEL_HI = SPAN_LSB + BASE_W;
    localparam int FIX_W  = BASE_W - MASK_W;
    localparam logic [FIX_W-1:0] FIX_CMP = '1;

    logic upper_clear;

    if (ADDR_W > SEL_HI) begin : g_upper
        assign upper_clear = (addr[ADDR_W-1:SEL_HI] == '0);
    end else begin : g_no_upper
        assign upper_clear = 1'b1;
    end

    for (genvar g = 0; g < N_CS; g++) begin : g_region
        region_cfg_t       cfg;
        logic [BASE_W-1:0] cmp_en;
        logic [BASE_W-1:0] diff;
        logic [OFS_W-1:0]  keep;

        assign cfg     = unpack_word(words[g*WORD_W +: WORD_W]);
        assign cmp_en  = {FIX_CMP, cfg.mask};
        assign diff    = (addr[SEL_HI-1:SPAN_LSB] ^ cfg.base) & cmp_en;
        assign match[g] = cfg.valid & ~blocked[g] & upper_clear & (diff == '0);
        assign cfg_err[g] = cfg.valid & ~mask_is_legal(cfg.mask, ALLOW_FULL_SPAN != 0);
        assign keep    = ~{cfg.mask, {SPAN_LSB{1'b0}}};
        assign offsets[g*OFS_W +: OFS_W] = addr[OFS_W-1:0] & keep;
    end

endmodule

// File: rtl/csd_pick.sv
module csd_pick
    import csd_pkg::*;
#(
    parameter int N_CS  = 8,
    parameter int IDX_W = 3,
    parameter int OFS_W = 28
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [N_CS-1:0]         match,
    input  logic [N_CS*OFS_W-1:0]   offsets,
    input  logic [2*N_CS-1:0]       dev_kind,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic                    rsp_miss,
    output logic                    rsp_overlap,
    output logic [N_CS-1:0]         rsp_cs,
    output logic [OFS_W-1:0]        rsp_offset,
    output logic                    rsp_to_mem,
    output logic                    rsp_to_nand
);

    logic [IDX_W-1:0] win_idx;
    logic             found;
    logic             multi;
    logic [1:0]       win_kind;
    logic [OFS_W-1:0] win_ofs;
    logic [N_CS-1:0]  win_onehot;
    logic             take;

    // fixed priority: lowest index wins
    always_comb begin
        win_idx = '0;
        found   = 1'b0;
        for (int i = N_CS - 1; i >= 0; i--) begin
            if (match[i]) begin
                win_idx = IDX_W'(i);
                found   = 1'b1;
            end
        end
        multi      = ($countones(match) > 1);
        win_kind   = dev_kind[win_idx*2 +: 2];
        win_ofs    = offsets[win_idx*OFS_W +: OFS_W];
        win_onehot = N_CS'(1) << win_idx;
        take       = req_valid & found;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_miss    <= 1'b0;
            rsp_overlap <= 1'b0;
            rsp_cs      <= '0;
            rsp_offset  <= '0;
            rsp_to_mem  <= 1'b0;
            rsp_to_nand <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_hit     <= take;
            rsp_miss    <= req_valid & ~found;
            rsp_overlap <= req_valid & multi;
            rsp_cs      <= take ? win_onehot : '0;
            rsp_offset  <= take ? win_ofs : '0;
            rsp_to_mem  <= take & (win_kind == KIND_MMIO);
            rsp_to_nand <= take & (win_kind == KIND_NAND);
        end
    end

endmodule

// File: rtl/cs_region_decoder.sv
module cs_region_decoder
    import csd_pkg::*;
#(
    parameter int N_CS            = 8,
    parameter int ADDR_W          = 32,
    parameter int SPAN_LSB        = 24,
    parameter int ALLOW_FULL_SPAN = 0,
    localparam int IDX_W          = (N_CS > 1) ? $clog2(N_CS) : 1,
    localparam int OFS_W          = SPAN_LSB + MASK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic [IDX_W-1:0]     cfg_wr_idx,
    input  logic [WORD_W-1:0]    cfg_wr_data,
    input  logic [IDX_W-1:0]     cfg_rd_idx,
    output logic [WORD_W-1:0]    cfg_rd_data,
    input  logic [2*N_CS-1:0]    dev_kind,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_miss,
    output logic                 rsp_overlap,
    output logic [N_CS-1:0]      rsp_cs,
    output logic [OFS_W-1:0]     rsp_offset,
    output logic                 rsp_to_mem,
    output logic                 rsp_to_nand,
    output logic [N_CS-1:0]      cfg_err
);

    logic [N_CS*WORD_W-1:0] words;
    logic [N_CS-1:0]        blocked;
    logic [N_CS-1:0]        match;
    logic [N_CS*OFS_W-1:0]  offsets;
    upd_state_e             upd_state;

    csd_region_file #(
        .N_CS  (N_CS),
        .IDX_W (IDX_W)
    ) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_idx  (cfg_wr_idx),
        .wr_data (cfg_wr_data),
        .rd_idx  (cfg_rd_idx),
        .rd_data (cfg_rd_data),
        .words   (words),
        .blocked (blocked),
        .state   (upd_state)
    );

    csd_match #(
        .N_CS            (N_CS),
        .ADDR_W          (ADDR_W),
        .SPAN_LSB        (SPAN_LSB),
        .OFS_W           (OFS_W),
        .ALLOW_FULL_SPAN (ALLOW_FULL_SPAN)
    ) u_match (
        .addr    (req_addr),
        .words   (words),
        .blocked (blocked),
        .match   (match),
        .cfg_err (cfg_err),
        .offsets (offsets)
    );

    csd_pick #(
        .N_CS  (N_CS),
        .IDX_W (IDX_W),
        .OFS_W (OFS_W)
    ) u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .match       (match),
        .offsets     (offsets),
        .dev_kind    (dev_kind),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_miss    (rsp_miss),
        .rsp_overlap (rsp_overlap),
        .rsp_cs      (rsp_cs),
        .rsp_offset  (rsp_offset),
        .rsp_to_mem  (rsp_to_mem),
        .rsp_to_nand (rsp_to_nand)
    );

endmodule

// File: rtl/cs_region_decoder_chk.sv
module cs_region_decoder_chk
    import csd_pkg::*;
#(
    parameter int N_CS  = 8,
    parameter int OFS_W = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic             rsp_overlap,
    input logic [N_CS-1:0]  rsp_cs,
    input logic [OFS_W-1:0] rsp_offset,
    input logic             rsp_to_mem,
    input logic             rsp_to_nand,
    input upd_state_e       upd_state,
    input logic [N_CS-1:0]  blocked
);

    p_cs_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot0(rsp_cs));

    p_overlap_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_overlap |-> rsp_hit);

    p_hit_or_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));

    p_miss_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_cs == '0 && rsp_offset == '0 && !rsp_to_mem && !rsp_to_nand));

    p_route_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_to_mem && rsp_to_nand));

    p_route_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_to_mem || rsp_to_nand) |-> rsp_hit);

    p_detach_to_attach_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_state == UPD_DETACH) |=> (upd_state == UPD_ATTACH));

    p_attach_to_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_state == UPD_ATTACH) |=> (upd_state == UPD_STEADY));

    p_single_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(blocked) <= 1);

    p_answer_next_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_answer_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss && rsp_cs == '0));

endmodule

bind cs_region_decoder cs_region_decoder_chk #(
    .N_CS  (N_CS),
    .OFS_W (OFS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_miss    (rsp_miss),
    .rsp_overlap (rsp_overlap),
    .rsp_cs      (rsp_cs),
    .rsp_offset  (rsp_offset),
    .rsp_to_mem  (rsp_to_mem),
    .rsp_to_nand (rsp_to_nand),
    .upd_state   (upd_state),
    .blocked     (blocked)
);

// File: tb/cs_region_decoder_test.sv
module cs_region_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_idx = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [2:0]  cfg_rd_idx = '0;
    logic [31:0] cfg_rd_data;
    logic [15:0] kinds = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_overlap, rsp_to_mem, rsp_to_nand;
    logic [7:0]  rsp_cs, cfg_err;
    logic [27:0] rsp_offset;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    logic [31:0] mw [8];

    always #10 clk = ~clk;

    cs_region_decoder uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data), .dev_kind(kinds),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_overlap(rsp_overlap), .rsp_cs(rsp_cs), .rsp_offset(rsp_offset),
        .rsp_to_mem(rsp_to_mem), .rsp_to_nand(rsp_to_nand), .cfg_err(cfg_err)
    );

    // {hit, miss, overlap, mem, nand, cs[7:0], offset[27:0]}
    function automatic logic [40:0] model_resp(input logic [31:0] a, input logic [7:0] blk);
        int cnt = 0;
        int win = 0;
        logic [31:0] w;
        logic hit;
        logic [1:0] kd;
        logic [27:0] ofs;
        for (int k = 7; k >= 0; k--) begin
            w = mw[k];
            if (w[6] && !blk[k] && a[31:30] == 2'b00 && a[29:28] == w[5:4]
                && (((a[27:24] ^ w[3:0]) & w[11:8]) == 4'h0)) begin
                cnt++;
                win = k;
            end
        end
        hit = (cnt > 0);
        kd  = kinds[win*2 +: 2];
        ofs = hit ? (a[27:0] & ~{mw[win][11:8], 24'h0}) : 28'h0;
        return {hit, !hit, cnt > 1, hit && kd == 2'd0, hit && kd == 2'd2,
                hit ? 8'(1 << win) : 8'h00, ofs};
    endfunction

    function automatic logic [7:0] model_err();
        logic [7:0] e;
        for (int k = 0; k < 8; k++)
            e[k] = mw[k][6] && !(mw[k][11:8] inside {4'h8, 4'hC, 4'hE, 4'hF});
        return e;
    endfunction

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic check_rsp(input string what, input logic [40:0] exp);
        check(what, {rsp_valid, rsp_hit, rsp_miss, rsp_overlap, rsp_to_mem, rsp_to_nand,
                     rsp_cs, rsp_offset}, {1'b1, exp});
    endtask

    // starts and ends at a falling edge
    task automatic req_check(input logic [31:0] a, input string what);
        logic [40:0] exp;
        req_valid = 1'b1;
        req_addr  = a;
        exp = model_resp(a, 8'h00);
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(what, exp);
    endtask

    task automatic cfg_write(input int idx, input logic [31:0] data);
        logic changed;
        changed = ((data & 32'h0000_0F7F) != mw[idx]);
        cfg_wr_en = 1'b1;
        cfg_wr_idx = 3'(idx);
        cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (changed) begin
            mw[idx] = data & 32'h0000_0F7F;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [40:0] exp;
        void'($urandom(32'd91357));
        mw[0] = 32'h0000_0F40;
        for (int k = 1; k < 8; k++) mw[k] = 32'h0000_0F00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R12: reset state
        check("R12 idle after reset", {rsp_valid, rsp_hit, rsp_miss, rsp_cs}, '0);
        for (int k = 0; k < 8; k++) begin
            cfg_rd_idx = 3'(k);
            #1 check("R2 reset word", cfg_rd_data, mw[k]);
        end
        check("R8 no error after reset", cfg_err, 8'h00);

        // R2 / R3 / R4: window 0 after reset
        req_check(32'h00AB_CDEF, "R4 window0 offset");
        req_check(32'h0100_0000, "R3 beyond window0");

        // R1: only stored bits kept
        cfg_write(3, 32'hFFFF_FFFF);
        cfg_rd_idx = 3'd3;
        #1 check("R1 stored bits", cfg_rd_data, 32'h0000_0F7F);
        req_check(32'h3F12_3456, "R3 top window");
        req_check(32'h7F12_3456, "R3 bit30 set");

        // R3 / R4: aliasing with mask 0xC
        cfg_write(2, 32'h0000_0C53);
        req_check(32'h1080_0000, "R3 alias low");
        req_check(32'h1234_5678, "R4 alias offset");
        req_check(32'h1434_5678, "R3 outside alias");

        // R5: overlap, lowest wins
        cfg_write(4, 32'h0000_0F52);
        req_check(32'h1200_0010, "R5 overlap priority");

        // R7: routing kinds
        kinds = 16'h0000 | (16'd2 << 4) | (16'd1 << 6) | (16'd3 << 8);
        req_check(32'h0000_0004, "R7 mmio route");
        req_check(32'h1100_0004, "R7 nand route");
        req_check(32'h3F00_0004, "R7 kind1 no route");
        req_check(32'h1200_0004, "R7 overlap keeps winner kind");

        // R10: write with no stored change keeps decoding
        cfg_wr_en = 1'b1; cfg_wr_idx = 3'd3; cfg_wr_data = 32'hABCD_0FFF;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        req_check(32'h3F00_0040, "R10 unchanged write");
        cfg_rd_idx = 3'd3;
        #1 check("R10 word kept", cfg_rd_data, 32'h0000_0F7F);

        // R8: illegal masks
        cfg_write(5, 32'h0000_0570);
        cfg_write(6, 32'h0000_0900);
        cfg_write(7, 32'h0000_0078);
        check("R8 illegal masks", cfg_err, model_err());
        check("R8 exact value", cfg_err, 8'hA0);

        // R9 / R11: decode and update in the same cycles
        cfg_wr_en = 1'b1; cfg_wr_idx = 3'd0; cfg_wr_data = 32'h0000_0F60;
        req_valid = 1'b1; req_addr = 32'h0000_0100;
        exp = model_resp(32'h0000_0100, 8'h00);
        @(negedge clk);
        check_rsp("R9 taken before detach", exp);
        cfg_rd_idx = 3'd0;
        #1 check("R9 old word in detach", cfg_rd_data, 32'h0000_0F40);
        cfg_wr_idx = 3'd1; cfg_wr_data = 32'h0000_0F45;
        exp = model_resp(32'h0000_0100, 8'h01);
        @(negedge clk);
        check_rsp("R9 excluded in detach", exp);
        check("R9 excluded miss", rsp_miss, 1'b1);
        check("R9 new word in attach", cfg_rd_data, 32'h0000_0F60);
        cfg_wr_en = 1'b0;
        mw[0] = 32'h0000_0F60;
        req_addr = 32'h2000_0100;
        exp = model_resp(32'h2000_0100, 8'h01);
        @(negedge clk);
        check_rsp("R9 excluded in attach", exp);
        exp = model_resp(32'h2000_0100, 8'h00);
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R9 new base after release", exp);
        check("R9 new base hit", rsp_cs, 8'h01);
        cfg_rd_idx = 3'd1;
        #1 check("R11 dropped write", cfg_rd_data, 32'h0000_0F00);
        req_check(32'h0000_0100, "R9 old base gone");

        @(negedge clk);
        check("R12 quiet without request", {rsp_valid, rsp_hit, rsp_miss, rsp_cs, rsp_offset}, '0);

        // random windows and requests
        for (int r = 0; r < 4; r++) begin
            kinds = 16'($urandom);
            for (int k = 0; k < 8; k++) begin
                logic [3:0] m;
                logic [31:0] d;
                case ($urandom % 6)
                    0: m = 4'h8;
                    1: m = 4'hC;
                    2: m = 4'hE;
                    3: m = 4'hF;
                    4: m = 4'h0;
                    default: m = 4'($urandom);
                endcase
                d = ($urandom & 32'hFFFF_F080) | (32'(m) << 8)
                    | (32'(($urandom % 4) != 0) << 6) | 32'($urandom % 64);
                cfg_write(k, d);
            end
            check("R8 random errors", cfg_err, model_err());
            for (int k = 0; k < 8; k++) begin
                cfg_rd_idx = 3'(k);
                #1 check("R1 random readback", cfg_rd_data, mw[k]);
            end
            for (int n = 0; n < 250; n++) begin
                logic [31:0] a;
                a = $urandom;
                if (($urandom % 4) != 0)
                    a = {2'b00, mw[$urandom % 8][5:4], a[27:0]};
                req_check(a, "R3 R5 R7 random decode");
            end
        end

        report();
    end

endmodule